// File: doc/BRIEF.md
# Register Bank Slave with Decode Error Responses

This block is an AXI4-Lite slave that holds a small bank of read/write control registers. The register bank sits inside the slave's address window of `2**ADDR_W` bytes. Register `i` sits at word index `i`, which is byte address `4*i`. Word indices from `NUM_REGS` up to the top of the window have no register behind them. All register contents are also driven out in parallel on `regs_o`, so that the surrounding logic can use them.

An access to an index with no register is an invalid access. With the build-time parameter `ERR_EN` set to 1, such an access still completes every handshake as normal, but it returns the error response code. With `ERR_EN` at 0, which is the default, an invalid access is answered OKAY, so a master sees no difference. In both settings an invalid write changes nothing, and an invalid read returns zero.

The block has two resets. The asynchronous power-on reset `por_n` clears the channel state and loads the register reset values. The synchronous `soft_rst` holds the registers at their reset values for as long as it is high. While `soft_rst` is high, every access is answered with the error code, whatever the setting of `ERR_EN`.

Top module: `axil_regbank`

## Requirements
- R1: The word index is `addr[ADDR_W-1:2]`, and byte-offset bits `[1:0]` are ignored. An index below `NUM_REGS` selects register `index`. A read of such an index, with `soft_rst` low, returns the register value with response OKAY (2'b00).
- R2: A write to a valid index while `soft_rst` is low replaces that register with the full `wdata` word. The new value is visible on `regs_o` and in later reads.
- R3: With `ERR_EN`=1, a write to an invalid index (index >= `NUM_REGS`) gets `bresp` = SLVERR (2'b10), and no register changes.
- R4: With `ERR_EN`=1, a read of an invalid index gets `rresp` = SLVERR (2'b10) with `rdata` = 0. Any response carrying SLVERR has `rdata` = 0.
- R5: With `ERR_EN`=0 and `soft_rst` low, every access is answered OKAY (2'b00). An invalid write changes nothing, and an invalid read returns 0.
- R6: Once raised, `bvalid` and `rvalid` stay high, with their response code and data unchanged, until `bready` or `rready` is seen high. Valid and error accesses use identical handshake timing.
- R7: Write address and write data may be accepted in either order and in different cycles. `awready` and `wready` are low while `bvalid` is high, so only one write is outstanding. Each of the two is also low once its own item has been taken for the current write.
- R8: `arready` is low exactly while `rvalid` is high, so only one read is outstanding.
- R9: While `soft_rst` is high at a clock edge, every register takes its reset value `RESET_BASE + i`. Every write committed or read accepted at such an edge is answered SLVERR (2'b10), and a read so answered returns 0.
- R10: While `por_n` is low, `bvalid` and `rvalid` are low, and every register holds `RESET_BASE + i`.
- R11: `rvalid` rises at the clock edge where the read address is accepted. `bvalid` rises at the clock edge after the edge where the later of the write address and the write data is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W | Write data |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code (00 OKAY, 10 SLVERR) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code (00 OKAY, 10 SLVERR) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| regs_o | output | NUM_REGS*DATA_W | All register contents, register i in bits [i*DATA_W +: DATA_W] |

## Verification
The assertions check the following on every cycle:
- responses held stable under back-pressure;
- the one-outstanding rules on both directions;
- zero data on every error read;
- register contents frozen across an erroring write;
- the soft-reset register values and error replies;
- the write-response timing relative to the internal commit.

Only the bench's scenarios can show the rest. That covers the decode itself: which indices count as registers, that the byte-offset bits are ignored, and that written values read back correctly. It also covers both orders of address and data, and the difference between the two `ERR_EN` settings under identical stimulus. For this, the bench drives two instances in lockstep and compares them against one behavioural model.

// File: rtl/axil_regbank_pkg.sv
package axil_regbank_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // word index carried in a byte address
  function automatic int unsigned word_idx(input logic [31:0] byte_addr);
    return int'(byte_addr >> 2);
  endfunction

  // a word index selects a register when it is below the register count
  function automatic logic is_hit(input int unsigned idx, input int unsigned nregs);
    return idx < nregs;
  endfunction

  // value a register takes on either reset
  function automatic logic [63:0] reset_word(input logic [63:0] base, input int unsigned idx);
    return base + 64'(idx);
  endfunction

  function automatic logic [1:0] resp_code(input logic err);
    return err ? RESP_SLVERR : RESP_OKAY;
  endfunction

endpackage

// File: rtl/axil_regbank_store.sv
module axil_regbank_store #(
  parameter int unsigned          NUM_REGS   = 6,
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          IDX_W      = 4,
  parameter logic [DATA_W-1:0]    RESET_BASE = '0
) (
  input  logic                         clk,
  input  logic                         por_n,
  input  logic                         soft_rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
  import axil_regbank_pkg::*;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = DATA_W'(reset_word(64'(RESET_BASE), i));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                            q <= RV;
      else if (soft_rst)                     q <= RV;
      else if (we && (widx == IDX_W'(i)))    q <= wdata;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/axil_regbank_wr.sv
module axil_regbank_wr #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 6,
  parameter bit          ERR_EN   = 1'b0,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               soft_rst,
  input  logic [ADDR_W-1:0]  awaddr,
  input  logic               awvalid,
  output logic               awready,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wvalid,
  output logic               wready,
  output logic [1:0]         bresp,
  output logic               bvalid,
  input  logic               bready,
  output logic               commit_o,
  output logic               commit_err_o,
  output logic               we_o,
  output logic [IDX_W-1:0]   widx_o,
  output logic [DATA_W-1:0]  wdata_o
);
  import axil_regbank_pkg::*;

  logic              aw_held, w_held;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic              hit;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held  && !bvalid;

  assign widx_o       = aw_addr_q[ADDR_W-1:2];
  assign hit          = is_hit(word_idx(32'(aw_addr_q)), NUM_REGS);
  assign commit_o     = aw_held && w_held;
  assign commit_err_o = soft_rst || (ERR_EN && !hit);
  assign we_o         = commit_o && hit && !soft_rst;
  assign wdata_o      = w_data_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      aw_held   <= 1'b0;
      w_held    <= 1'b0;
      aw_addr_q <= '0;
      w_data_q  <= '0;
      bvalid    <= 1'b0;
      bresp     <= RESP_OKAY;
    end else begin
      if (bvalid && bready) bvalid <= 1'b0;
      if (commit_o) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
        bresp   <= resp_code(commit_err_o);
      end else begin
        if (awvalid && awready) begin
          aw_held   <= 1'b1;
          aw_addr_q <= awaddr;
        end
        if (wvalid && wready) begin
          w_held   <= 1'b1;
          w_data_q <= wdata;
        end
      end
    end
  end

endmodule

// File: rtl/axil_regbank_rd.sv
module axil_regbank_rd #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 6,
  parameter bit          ERR_EN   = 1'b0,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        soft_rst,
  input  logic [ADDR_W-1:0]           araddr,
  input  logic                        arvalid,
  output logic                        arready,
  output logic [DATA_W-1:0]           rdata,
  output logic [1:0]                  rresp,
  output logic                        rvalid,
  input  logic                        rready,
  input  logic [NUM_REGS*DATA_W-1:0]  regs_flat,
  output logic                        accept_o,
  output logic                        err_o
);
  import axil_regbank_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [DATA_W-1:0] sel;

  assign arready  = !rvalid;
  assign accept_o = arvalid && arready;
  assign idx      = araddr[ADDR_W-1:2];
  assign hit      = is_hit(word_idx(32'(araddr)), NUM_REGS);
  assign err_o    = soft_rst || (ERR_EN && !hit);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) sel = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else begin
      if (rvalid && rready) rvalid <= 1'b0;
      if (accept_o) begin
        rvalid <= 1'b1;
        rresp  <= resp_code(err_o);
        rdata  <= (hit && !soft_rst) ? sel : '0;
      end
    end
  end

endmodule

// File: rtl/axil_regbank.sv
module axil_regbank #(
  parameter int unsigned       ADDR_W     = 6,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       NUM_REGS   = 6,
  parameter bit                ERR_EN     = 1'b0,
  parameter logic [DATA_W-1:0] RESET_BASE = DATA_W'(32'hC0DE_0000)
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        soft_rst,
  input  logic [ADDR_W-1:0]           awaddr,
  input  logic                        awvalid,
  output logic                        awready,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        wvalid,
  output logic                        wready,
  output logic [1:0]                  bresp,
  output logic                        bvalid,
  input  logic                        bready,
  input  logic [ADDR_W-1:0]           araddr,
  input  logic                        arvalid,
  output logic                        arready,
  output logic [DATA_W-1:0]           rdata,
  output logic [1:0]                  rresp,
  output logic                        rvalid,
  input  logic                        rready,
  output logic [NUM_REGS*DATA_W-1:0]  regs_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  // internal events, named for the checker
  logic                       wr_commit, wr_err, wr_we;
  logic [IDX_W-1:0]           wr_idx;
  logic [DATA_W-1:0]          wr_data;
  logic                       rd_accept, rd_err;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  axil_regbank_wr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ERR_EN(ERR_EN)
  ) u_wr (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .commit_o(wr_commit), .commit_err_o(wr_err), .we_o(wr_we),
    .widx_o(wr_idx), .wdata_o(wr_data)
  );

  axil_regbank_store #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .RESET_BASE(RESET_BASE)
  ) u_store (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .we(wr_we), .widx(wr_idx), .wdata(wr_data), .regs_flat(regs_flat)
  );

  axil_regbank_rd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ERR_EN(ERR_EN)
  ) u_rd (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .regs_flat(regs_flat), .accept_o(rd_accept), .err_o(rd_err)
  );

  assign regs_o = regs_flat;

endmodule

// File: rtl/axil_regbank_chk.sv
module axil_regbank_chk #(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       NUM_REGS   = 6,
  parameter bit                ERR_EN     = 1'b0,
  parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
  input logic                        clk,
  input logic                        por_n,
  input logic                        soft_rst,
  input logic                        awready,
  input logic                        wready,
  input logic [1:0]                  bresp,
  input logic                        bvalid,
  input logic                        bready,
  input logic                        arvalid,
  input logic                        arready,
  input logic [DATA_W-1:0]           rdata,
  input logic [1:0]                  rresp,
  input logic                        rvalid,
  input logic                        rready,
  input logic [NUM_REGS*DATA_W-1:0]  regs_o,
  input logic                        wr_commit,
  input logic                        wr_err,
  input logic                        rd_accept,
  input logic                        rd_err
);
  import axil_regbank_pkg::*;

  function automatic logic [NUM_REGS*DATA_W-1:0] build_reset_vec();
    logic [NUM_REGS*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_REGS; i++)
      v[i*DATA_W +: DATA_W] = DATA_W'(reset_word(64'(RESET_BASE), i));
    return v;
  endfunction

  localparam logic [NUM_REGS*DATA_W-1:0] RST_VEC = build_reset_vec();

  assert_bresp_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    bvalid && !bready |=> bvalid && $stable(bresp));

  assert_rresp_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    rvalid && !rready |=> rvalid && $stable(rresp) && $stable(rdata));

  assert_one_write_R7: assert property (@(posedge clk) disable iff (!por_n)
    bvalid |-> !awready && !wready);

  assert_one_read_R8: assert property (@(posedge clk) disable iff (!por_n)
    rvalid |-> !arready);

  assert_soft_regs_R9: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> regs_o == RST_VEC);

  assert_soft_read_R9: assert property (@(posedge clk) disable iff (!por_n)
    rd_accept && soft_rst |=> rvalid && rresp == RESP_SLVERR && rdata == '0);

  assert_err_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
    rvalid && rresp == RESP_SLVERR |-> rdata == '0);

  assert_okay_when_off_R5: assert property (@(posedge clk) disable iff (!por_n)
    rd_accept && !soft_rst && !ERR_EN |=> rresp == RESP_OKAY);

  assert_err_keeps_regs_R3: assert property (@(posedge clk) disable iff (!por_n)
    wr_commit && wr_err && !soft_rst |=> $stable(regs_o));

  assert_bvalid_after_commit_R11: assert property (@(posedge clk) disable iff (!por_n)
    wr_commit |=> bvalid && bresp == resp_code($past(wr_err)));

  assert_read_err_code_R4: assert property (@(posedge clk) disable iff (!por_n)
    rd_accept |=> rresp == resp_code($past(rd_err)));

  assert_legal_codes_R1: assert property (@(posedge clk) disable iff (!por_n)
    bvalid |-> (bresp == RESP_OKAY || bresp == RESP_SLVERR));

endmodule

bind axil_regbank axil_regbank_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ERR_EN(ERR_EN), .RESET_BASE(RESET_BASE)
) u_chk (
  .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
  .awready(awready), .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready),
  .arvalid(arvalid), .arready(arready), .rdata(rdata), .rresp(rresp),
  .rvalid(rvalid), .rready(rready), .regs_o(regs_o),
  .wr_commit(wr_commit), .wr_err(wr_err), .rd_accept(rd_accept), .rd_err(rd_err)
);

// File: tb/test_axil_regbank.sv
`timescale 1ns/1ps
module test_axil_regbank;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 6;
  localparam int unsigned NWORD  = 16;
  localparam logic [31:0] RBASE  = 32'hC0DE_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic              por_n, soft_rst;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic              awvalid, wvalid, bready, arvalid, rready;
  logic [DATA_W-1:0] wdata;

  // instance with error reporting on, and a twin with it off
  logic              awr_a, wr_a, bv_a, arr_a, rv_a;
  logic [1:0]        br_a, rr_a;
  logic [DATA_W-1:0] rd_a;
  logic [NREG*DATA_W-1:0] regs_a;
  logic              awr_b, wr_b, bv_b, arr_b, rv_b;
  logic [1:0]        br_b, rr_b;
  logic [DATA_W-1:0] rd_b;
  logic [NREG*DATA_W-1:0] regs_b;

  axil_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NREG), .ERR_EN(1'b1),
                 .RESET_BASE(RBASE)) i_axil_regbank (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awr_a),
    .wdata(wdata), .wvalid(wvalid), .wready(wr_a),
    .bresp(br_a), .bvalid(bv_a), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arr_a),
    .rdata(rd_a), .rresp(rr_a), .rvalid(rv_a), .rready(rready), .regs_o(regs_a));

  axil_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NREG), .ERR_EN(1'b0),
                 .RESET_BASE(RBASE)) i_axil_regbank_off (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awr_b),
    .wdata(wdata), .wvalid(wvalid), .wready(wr_b),
    .bresp(br_b), .bvalid(bv_b), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arr_b),
    .rdata(rd_b), .rresp(rr_b), .rvalid(rv_b), .rready(rready), .regs_o(regs_b));

  int compared = 0;
  int mismatched = 0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [NREG];
  bit          m_aw_got, m_w_got, m_bv, m_rv;
  int          m_aw_word;
  logic [31:0] m_w_word, m_rdata;
  logic [1:0]  m_bresp_on, m_bresp_off, m_rresp_on, m_rresp_off;
  bit          cmp_on = 0;

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m_reg[i] = RBASE + i;
    m_aw_got = 0; m_w_got = 0; m_bv = 0; m_rv = 0;
    m_rdata = 0; m_bresp_on = 0; m_bresp_off = 0; m_rresp_on = 0; m_rresp_off = 0;
  endtask

  initial model_reset();

  function automatic logic [NREG*DATA_W-1:0] model_flat();
    logic [NREG*DATA_W-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DATA_W +: DATA_W] = m_reg[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      model_reset();
    end else begin
      bit aw_ok, w_ok, ar_ok, take_aw, take_w;
      logic [31:0] snap [NREG];
      int ridx;
      aw_ok = !m_aw_got && !m_bv;
      w_ok  = !m_w_got && !m_bv;
      ar_ok = !m_rv;
      take_aw = awvalid && aw_ok;
      take_w  = wvalid && w_ok;
      for (int i = 0; i < NREG; i++) snap[i] = m_reg[i];
      // read side sees the registers as they were before this edge
      if (m_rv && rready) m_rv = 0;
      if (arvalid && ar_ok) begin
        ridx = int'(araddr) / 4;
        m_rv = 1;
        m_rdata     = (ridx < NREG && !soft_rst) ? snap[ridx] : 32'h0;
        m_rresp_on  = (soft_rst || ridx >= NREG) ? 2'b10 : 2'b00;
        m_rresp_off = soft_rst ? 2'b10 : 2'b00;
      end
      // write side
      if (m_bv && bready) m_bv = 0;
      if (m_aw_got && m_w_got) begin
        m_aw_got = 0; m_w_got = 0; m_bv = 1;
        m_bresp_on  = (soft_rst || m_aw_word >= NREG) ? 2'b10 : 2'b00;
        m_bresp_off = soft_rst ? 2'b10 : 2'b00;
        if (!soft_rst && m_aw_word < NREG) m_reg[m_aw_word] = m_w_word;
      end else begin
        if (take_aw) begin m_aw_got = 1; m_aw_word = int'(awaddr) / 4; end
        if (take_w)  begin m_w_got = 1;  m_w_word = wdata; end
      end
      if (soft_rst) for (int i = 0; i < NREG; i++) m_reg[i] = RBASE + i;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(awr_a == (!m_aw_got && !m_bv) && awr_b == awr_a, "R7", "awready",
            {awr_a, awr_b}, {2{!m_aw_got && !m_bv}});
      check(wr_a == (!m_w_got && !m_bv) && wr_b == wr_a, "R7", "wready",
            {wr_a, wr_b}, {2{!m_w_got && !m_bv}});
      check(arr_a == !m_rv && arr_b == !m_rv, "R8", "arready", {arr_a, arr_b}, {2{!m_rv}});
      check(bv_a == m_bv && bv_b == m_bv, "R11/R10", "bvalid", {bv_a, bv_b}, {2{m_bv}});
      check(rv_a == m_rv && rv_b == m_rv, "R11/R10", "rvalid", {rv_a, rv_b}, {2{m_rv}});
      if (m_bv) begin
        check(br_a == m_bresp_on, "R3/R6/R9", "bresp err-on", br_a, m_bresp_on);
        check(br_b == m_bresp_off, "R5/R6/R9", "bresp err-off", br_b, m_bresp_off);
      end
      if (m_rv) begin
        check(rd_a == m_rdata && rd_b == m_rdata, "R1/R4/R5", "rdata", {rd_a, rd_b}, {2{m_rdata}});
        check(rr_a == m_rresp_on, "R4/R6/R9", "rresp err-on", rr_a, m_rresp_on);
        check(rr_b == m_rresp_off, "R5/R6/R9", "rresp err-off", rr_b, m_rresp_off);
      end
      check(regs_a == model_flat(), "R2/R3/R9/R10", "regs err-on", regs_a, model_flat());
      check(regs_b == model_flat(), "R2/R5/R9/R10", "regs err-off", regs_b, model_flat());
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_aw(input logic [ADDR_W-1:0] a, input int dly);
    repeat (dly) @(negedge clk);
    awaddr = a; awvalid = 1;
    while (!awr_a) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input int dly);
    repeat (dly) @(negedge clk);
    wdata = d; wvalid = 1;
    while (!wr_a) @(negedge clk);
    @(negedge clk);
    wvalid = 0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input int da, input int dw, input int stall);
    bready = (stall == 0);
    fork
      send_aw(a, da);
      send_w(d, dw);
    join
    while (!bv_a) @(negedge clk);
    repeat (stall) @(negedge clk);
    bready = 1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input int stall);
    rready = (stall == 0);
    araddr = a; arvalid = 1;
    while (!arr_a) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    repeat (stall) @(negedge clk);
    rready = 1;
    while (!(rv_a && rready)) @(negedge clk);
    @(negedge clk);
  endtask

  bit timed_out = 0;

  initial begin
    por_n = 0; soft_rst = 0;
    awaddr = 0; awvalid = 0; wdata = 0; wvalid = 0; bready = 1;
    araddr = 0; arvalid = 0; rready = 1;
    repeat (2) @(negedge clk);
    cmp_on = 1;                          // R10: outputs under power-on reset
    repeat (2) @(negedge clk);
    por_n = 1;
    fork
      begin
        // R10/R1/R4/R5: every word of the window after reset
        for (int i = 0; i < NWORD; i++) do_read(ADDR_W'(i * 4), 0);
        // R2: fill registers, address and data in varying order (R7)
        for (int i = 0; i < NREG; i++)
          do_write(ADDR_W'(i * 4), 32'h1000_0000 + 32'(i * 32'h0101_0101), i % 3, (i + 1) % 3, 0);
        // R3/R5: invalid writes leave everything alone
        do_write(ADDR_W'(NREG * 4), 32'hDEAD_BEEF, 0, 0, 0);
        do_write(ADDR_W'(15 * 4), 32'hFFFF_FFFF, 3, 0, 0);
        do_write(ADDR_W'(9 * 4 + 2), 32'h1234_5678, 0, 4, 0);
        // R1: read back, byte offset bits ignored
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i * 4 + (i % 4)), 0);
        do_read(ADDR_W'(11 * 4), 0);
        // R6: responses held under back-pressure, valid and invalid
        do_write(ADDR_W'(2 * 4), 32'hA5A5_5A5A, 1, 0, 5);
        do_write(ADDR_W'(12 * 4), 32'h0BAD_F00D, 0, 2, 4);
        do_read(ADDR_W'(2 * 4), 6);
        do_read(ADDR_W'(13 * 4), 3);
        // R7: address long before data
        do_write(ADDR_W'(4 * 4), 32'h4444_4444, 0, 7, 0);
        do_write(ADDR_W'(5 * 4), 32'h5555_5555, 6, 0, 0);
        // R9: soft reset holds registers and errors every access
        soft_rst = 1;
        @(negedge clk);
        do_write(ADDR_W'(1 * 4), 32'h7777_7777, 0, 1, 0);
        do_read(ADDR_W'(3 * 4), 0);
        do_read(ADDR_W'(14 * 4), 2);
        // write whose data arrives as soft reset drops
        fork
          do_write(ADDR_W'(0), 32'h0F0F_0F0F, 0, 2, 0);
          begin @(negedge clk); @(negedge clk); soft_rst = 0; end
        join
        for (int i = 0; i < NREG; i++) do_read(ADDR_W'(i * 4), 0);
        // R2 after soft reset
        do_write(ADDR_W'(3 * 4), 32'h3333_0003, 0, 0, 0);
        do_read(ADDR_W'(3 * 4), 1);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule